// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

The block gathers a parameterised set of interrupt lines (a multiple of 32, at most 128) and presents the single most urgent one to the interface of one processor. Each line has an enable bit, a trigger mode (level-high or edge-rising), an eight-bit CPU target mask and an eight-bit priority. All of this state sits behind a plain 32-bit register bus with a byte address, a write strobe, write data and registered read data. The lowest sixteen IDs carry no input wire. Software raises them by writing a request word, and they are always edge-triggered and always enabled.

The processor side sees `fwd_valid`, `fwd_id` and `fwd_prio`. It takes the offered interrupt with a one-cycle `fwd_ack`. That marks the interrupt active and clears a latched edge. It later retires the interrupt by pulsing `eoi_valid` with the ID on `eoi_id`. An active interrupt is never offered again until it is retired.

Top module: `irq_dist`

## Requirements
- R1: Enable bits pack 32 IDs per word, with ID 32w+b at bit b. Writing word w at 0x100+4w sets every bit written as 1. Writing at 0x140+4w clears every bit written as 1. Bits written as 0 keep their value, and both addresses read back the current enables.
- R2: IDs 0..15 are permanently enabled and always read as enabled. Clear writes to them have no effect, and `irq_in` bits 0..15 are ignored.
- R3: Trigger words sit at 0x400+4w, with two bits per ID and ID 16w+k at bits 2k+1:2k. The upper bit selects edge-rising (1) or level-high (0), and the lower bit always reads 0. IDs 0..15 always read 2'b10 and ignore writes.
- R4: Priority bytes sit at 0x200+4w and target bytes at 0x300+4w, with ID 4w+j in byte j. Target bit n means CPU n. After reset all priorities are 0x00 and all targets are 0x01.
- R5: The read-only word at 0x004 holds NUM_IRQ/32-1 in bits 4:0 (capped at the value for 1020 lines). Writes to it are ignored.
- R6: A write to 0x008 whose bit 16 (CPU 0 in the target list in bits 23:16) is set makes the ID in bits 3:0 pending. If bit 16 is clear, nothing becomes pending.
- R7: Bit 0 at 0x000 globally enables forwarding. While it is 0, `fwd_valid` is 0. Whenever nothing is offered, `fwd_id` is 1023.
- R8: A level-mode ID is pending exactly while its input is high. An edge-mode ID latches pending on a rising input edge and clears on acknowledge. Pending bits read back at 0x180+4w, 32 IDs per word.
- R9: Among enabled, pending, non-active IDs whose target bit 0 is set, the one with the numerically lowest priority is offered. Ties go to the lowest ID.
- R10: `fwd_ack` while `fwd_valid` makes the offered ID active, so it is no longer offered. `eoi_valid` with its ID makes it inactive again.
- R11: After reset, forwarding is off, enables for IDs 16 and up are 0, and no ID is pending or active. Reads return data one clock after the address, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_IRQ | Interrupt input lines, bits 0..15 unused |
| fwd_valid | output | 1 | An interrupt is offered to CPU 0 |
| fwd_id | output | 10 | Offered ID, 1023 when idle |
| fwd_prio | output | 8 | Priority of the offered ID |
| fwd_ack | input | 1 | Acknowledge of the offered ID |
| eoi_valid | input | 1 | End of service strobe |
| eoi_id | input | 10 | ID being retired |

## Verification
A register write changes state at the next clock edge, and the offered interrupt follows one edge later. A level input therefore shows up on `fwd_*` one edge after it changes. An edge input needs two edges: one to latch and one to forward. Read data is due one edge after the address. The bench drives every stimulus at a falling edge and waits three falling edges before it compares `fwd_*`. It samples `bus_rdata` at the falling edge after the capturing rising edge, so every result is checked once it has settled.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int ID_W    = 10;
    localparam int NUM_SGI = 16;
    localparam int MAX_LINES = 1020;

    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

    localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
    localparam logic [ADDR_W-1:0] A_TYPE  = 12'h004;
    localparam logic [ADDR_W-1:0] A_SWINT = 12'h008;
    localparam logic [ADDR_W-1:0] A_ENSET = 12'h100;
    localparam logic [ADDR_W-1:0] A_ENCLR = 12'h140;
    localparam logic [ADDR_W-1:0] A_PEND  = 12'h180;
    localparam logic [ADDR_W-1:0] A_PRIO  = 12'h200;
    localparam logic [ADDR_W-1:0] A_TGT   = 12'h300;
    localparam logic [ADDR_W-1:0] A_CFG   = 12'h400;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
        logic [7:0]      prio;
    } fwd_t;

    function automatic logic [4:0] type_code(int lines);
        int capped;
        capped = (lines > MAX_LINES) ? MAX_LINES : lines;
        return 5'((capped + 31) / 32 - 1);
    endfunction

    function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] base, int idx);
        return base + ADDR_W'(idx * 4);
    endfunction
endpackage

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_IRQ-1:0]       pend_view,
    output logic                     ctrl_en,
    output logic [NUM_IRQ-1:0]       en,
    output logic [NUM_IRQ-1:0]       cfg_edge,
    output logic [NUM_IRQ-1:0][7:0]  prio,
    output logic [NUM_IRQ-1:0]       tgt_cpu0,
    output logic [NUM_SGI-1:0]       sgi_set
);
    localparam int EN_WORDS   = NUM_IRQ / 32;
    localparam int BYTE_WORDS = NUM_IRQ / 4;
    localparam int CFG_WORDS  = NUM_IRQ / 16;
    localparam logic [NUM_IRQ-1:0] SGI_MASK = NUM_IRQ'({NUM_SGI{1'b1}});

    logic                     ctrl_q;
    logic [NUM_IRQ-1:0]       en_q;
    logic [NUM_IRQ-1:0]       cfg_q;
    logic [NUM_IRQ-1:0][7:0]  prio_q;
    logic [NUM_IRQ-1:0][7:0]  tgt_q;
    logic [DATA_W-1:0]        rd_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
            en_q   <= '0;
            cfg_q  <= '0;
            prio_q <= '0;
            tgt_q  <= {NUM_IRQ{8'h01}};
        end else if (bus_we) begin
            if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[0];
            for (int w = 0; w < EN_WORDS; w++) begin
                if (bus_addr == word_addr(A_ENSET, w))
                    en_q[w*32 +: 32] <= en_q[w*32 +: 32] | bus_wdata;
                if (bus_addr == word_addr(A_ENCLR, w))
                    en_q[w*32 +: 32] <= en_q[w*32 +: 32] & ~bus_wdata;
            end
            for (int w = 0; w < CFG_WORDS; w++) begin
                if (bus_addr == word_addr(A_CFG, w))
                    for (int k = 0; k < 16; k++) cfg_q[w*16 + k] <= bus_wdata[2*k + 1];
            end
            for (int w = 0; w < BYTE_WORDS; w++) begin
                for (int j = 0; j < 4; j++) begin
                    if (bus_addr == word_addr(A_PRIO, w)) prio_q[w*4 + j] <= bus_wdata[8*j +: 8];
                    if (bus_addr == word_addr(A_TGT, w))  tgt_q[w*4 + j]  <= bus_wdata[8*j +: 8];
                end
            end
        end
    end

    // Software-generated IDs: locked enabled and edge-triggered
    assign en       = en_q | SGI_MASK;
    assign cfg_edge = cfg_q | SGI_MASK;
    assign ctrl_en  = ctrl_q;
    assign prio     = prio_q;

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_tgt
            assign tgt_cpu0[i] = tgt_q[i][0];
        end
    endgenerate

    assign sgi_set = (bus_we && bus_addr == A_SWINT && bus_wdata[16])
                   ? (NUM_SGI'(1) << bus_wdata[3:0]) : '0;

    always_comb begin
        rd_d = '0;
        if (bus_addr == A_CTRL) rd_d[0] = ctrl_q;
        if (bus_addr == A_TYPE) rd_d[4:0] = type_code(NUM_IRQ);
        for (int w = 0; w < EN_WORDS; w++) begin
            if (bus_addr == word_addr(A_ENSET, w) || bus_addr == word_addr(A_ENCLR, w))
                rd_d = en[w*32 +: 32];
            if (bus_addr == word_addr(A_PEND, w))
                rd_d = pend_view[w*32 +: 32];
        end
        for (int w = 0; w < BYTE_WORDS; w++) begin
            for (int j = 0; j < 4; j++) begin
                if (bus_addr == word_addr(A_PRIO, w)) rd_d[8*j +: 8] = prio_q[w*4 + j];
                if (bus_addr == word_addr(A_TGT, w))  rd_d[8*j +: 8] = tgt_q[w*4 + j];
            end
        end
        for (int w = 0; w < CFG_WORDS; w++) begin
            if (bus_addr == word_addr(A_CFG, w))
                for (int k = 0; k < 16; k++) rd_d[2*k + 1] = cfg_edge[w*16 + k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_d;
    end

    AST_ENSET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_ENSET) |=> ((en[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R1
    AST_ENCLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_ENCLR) |=> ((en[31:16] & $past(bus_wdata[31:16])) == 16'h0)); // R1
endmodule

// File: rtl/irq_dist_pend.sv
module irq_dist_pend
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] cfg_edge,
    input  logic [NUM_SGI-1:0] sgi_set,
    input  logic               ack,
    input  logic [ID_W-1:0]    ack_id,
    input  logic               eoi,
    input  logic [ID_W-1:0]    eoi_id,
    output logic [NUM_IRQ-1:0] pend,
    output logic [NUM_IRQ-1:0] act
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic [NUM_IRQ-1:0] prev_q, edge_q, act_q, set_v;
    logic               unused_lo;

    generate
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
            if (i < NUM_SGI) begin : g_sgi
                assign set_v[i] = sgi_set[i];
                assign pend[i]  = edge_q[i];
            end else begin : g_per
                assign set_v[i] = irq_in[i] & ~prev_q[i] & cfg_edge[i];
                assign pend[i]  = cfg_edge[i] ? edge_q[i] : irq_in[i];
            end
        end
    endgenerate

    assign unused_lo = ^{irq_in[NUM_SGI-1:0], prev_q[NUM_SGI-1:0], cfg_edge[NUM_SGI-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            edge_q <= '0;
            act_q  <= '0;
        end else begin
            prev_q <= irq_in;
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (set_v[i])                        edge_q[i] <= 1'b1;
                else if (ack && ack_id == ID_W'(i))  edge_q[i] <= 1'b0;
                if (ack && ack_id == ID_W'(i))       act_q[i]  <= 1'b1;
                else if (eoi && eoi_id == ID_W'(i))  act_q[i]  <= 1'b0;
            end
        end
    end

    assign act = act_q;

    AST_ACK_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        ack |=> act_q[$past(ack_id[IDX_W-1:0])]); // R10
    AST_ACK_CLEARS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (ack && !set_v[ack_id[IDX_W-1:0]]) |=> !edge_q[$past(ack_id[IDX_W-1:0])]); // R8
endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]      elig,
    input  logic [NUM_IRQ-1:0][7:0] prio,
    output logic                    found,
    output logic [ID_W-1:0]         best_id,
    output logic [7:0]              best_prio
);
    // Ascending scan with strict compare: equal priority keeps the lower ID
    always_comb begin
        found     = 1'b0;
        best_id   = ID_NONE;
        best_prio = 8'h00;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!found || prio[i] < best_prio)) begin
                found     = 1'b1;
                best_id   = ID_W'(i);
                best_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_IRQ-1:0]    irq_in,
    output logic                  fwd_valid,
    output logic [ID_W-1:0]       fwd_id,
    output logic [7:0]            fwd_prio,
    input  logic                  fwd_ack,
    input  logic                  eoi_valid,
    input  logic [ID_W-1:0]       eoi_id
);
    localparam int IDX_W = $clog2(NUM_IRQ);

    logic                     ctrl_en;
    logic [NUM_IRQ-1:0]       en, cfg_edge, tgt_cpu0, pend, act, elig;
    logic [NUM_IRQ-1:0][7:0]  prio;
    logic [NUM_SGI-1:0]       sgi_set;
    logic                     arb_found;
    logic [ID_W-1:0]          arb_id;
    logic [7:0]               arb_prio;
    logic                     ack_fire;
    fwd_t                     fwd_q;

    irq_dist_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_view(pend),
        .ctrl_en(ctrl_en), .en(en), .cfg_edge(cfg_edge), .prio(prio),
        .tgt_cpu0(tgt_cpu0), .sgi_set(sgi_set)
    );

    assign ack_fire = fwd_ack & fwd_q.valid;

    irq_dist_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_edge(cfg_edge),
        .sgi_set(sgi_set), .ack(ack_fire), .ack_id(fwd_q.id),
        .eoi(eoi_valid), .eoi_id(eoi_id), .pend(pend), .act(act)
    );

    assign elig = {NUM_IRQ{ctrl_en}} & en & pend & ~act & tgt_cpu0;

    irq_dist_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .elig(elig), .prio(prio), .found(arb_found),
        .best_id(arb_id), .best_prio(arb_prio)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_q <= '{valid: 1'b0, id: ID_NONE, prio: 8'h00};
        end else begin
            fwd_q.valid <= arb_found;
            fwd_q.id    <= arb_found ? arb_id : ID_NONE;
            fwd_q.prio  <= arb_found ? arb_prio : 8'h00;
        end
    end

    assign fwd_valid = fwd_q.valid;
    assign fwd_id    = fwd_q.id;
    assign fwd_prio  = fwd_q.prio;

    AST_CTRL_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> !fwd_valid); // R7
    AST_PICK_IS_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        arb_found |-> elig[arb_id[IDX_W-1:0]]); // R9
    AST_IDLE_ID: assert property (@(posedge clk) disable iff (rst)
        !fwd_valid |-> (fwd_id == ID_NONE)); // R7
endmodule

// File: tb/tb_irq_dist.sv
`timescale 1ns/1ps
module tb_irq_dist;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in;
    logic        fwd_valid;
    logic [9:0]  fwd_id;
    logic [7:0]  fwd_prio;
    logic        fwd_ack;
    logic        eoi_valid;
    logic [9:0]  eoi_id;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    bit [7:0] prio_m [N];
    bit [7:0] tgt_m  [N];
    bit [N-1:0] en_m;

    always #10 clk = ~clk;

    irq_dist #(.NUM_IRQ(N)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_prio(fwd_prio),
        .fwd_ack(fwd_ack), .eoi_valid(eoi_valid), .eoi_id(eoi_id)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk); fwd_ack = 1'b1;
        @(negedge clk); fwd_ack = 1'b0;
    endtask

    task automatic do_eoi(int id);
        @(negedge clk); eoi_valid = 1'b1; eoi_id = 10'(id);
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic expect_fwd(string req, bit v, int id, int pr);
        check({req, " valid"}, 32'(fwd_valid), 32'(v));
        check({req, " id"}, 32'(fwd_id), v ? 32'(id) : 32'd1023);
        if (v) check({req, " prio"}, 32'(fwd_prio), 32'(pr));
    endtask

    function automatic void ref_arb(bit [N-1:0] lines, output bit v, output int id, output int pr);
        v = 0; id = 1023; pr = 0;
        for (int i = 16; i < N; i++) begin
            if (en_m[i] && lines[i] && tgt_m[i][0] && (!v || prio_m[i] < pr)) begin
                v = 1; id = i; pr = prio_m[i];
            end
        end
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        logic [31:0] d;
        bit v; int id; int pr;
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; irq_in = '0;
        fwd_ack = 1'b0; eoi_valid = 1'b0; eoi_id = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        rd(12'h000, d); check("R11 ctrl reset", d, 32'h0);
        rd(12'h004, d); check("R5 type", d, 32'h1);
        rd(12'h100, d); check("R2 sgi enables at reset", d, 32'h0000FFFF);
        rd(12'h104, d); check("R11 enables reset", d, 32'h0);
        rd(12'h214, d); check("R4 prio reset", d, 32'h0);
        rd(12'h314, d); check("R4 target reset", d, 32'h01010101);
        rd(12'h180, d); check("R11 pending reset", d, 32'h0);
        rd(12'h7F0, d); check("R11 unmapped read", d, 32'h0);
        expect_fwd("R7 idle after reset", 0, 0, 0);

        wr(12'h004, 32'h1F); rd(12'h004, d); check("R5 type read-only", d, 32'h1);

        // Trigger configuration
        wr(12'h400, 32'h0); rd(12'h400, d); check("R3 sgi cfg locked", d, 32'hAAAAAAAA);
        wr(12'h404, 32'hFFFFFFFF); rd(12'h404, d); check("R3 cfg upper bits only", d, 32'hAAAAAAAA);
        wr(12'h404, 32'h0); rd(12'h404, d); check("R3 cfg back to level", d, 32'h0);

        // Enable set/clear views
        wr(12'h104, 32'h00F00000); wr(12'h104, 32'h0000000F);
        rd(12'h104, d); check("R1 set view accumulates", d, 32'h00F0000F);
        wr(12'h144, 32'h00300001);
        rd(12'h144, d); check("R1 clear view", d, 32'h00C0000E);
        wr(12'h140, 32'hFFFFFFFF);
        rd(12'h100, d); check("R2 sgi enable clear ignored", d, 32'h0000FFFF);
        wr(12'h144, 32'hFFFFFFFF);

        // Random level-mode arbitration
        wr(12'h000, 32'h1);
        for (int it = 0; it < 25; it++) begin
            bit [N-1:0] lines;
            for (int i = 16; i < N; i++) begin
                prio_m[i] = 8'($urandom_range(0, 7));
                tgt_m[i]  = 8'($urandom);
            end
            for (int w = 4; w < N/4; w++) begin
                wr(12'h200 + 12'(4*w), {prio_m[4*w+3], prio_m[4*w+2], prio_m[4*w+1], prio_m[4*w]});
                wr(12'h300 + 12'(4*w), {tgt_m[4*w+3], tgt_m[4*w+2], tgt_m[4*w+1], tgt_m[4*w]});
            end
            en_m = {32'($urandom), 32'($urandom) & 32'hFFFF0000};
            wr(12'h140, 32'hFFFFFFFF); wr(12'h144, 32'hFFFFFFFF);
            wr(12'h100, en_m[31:0]); wr(12'h104, en_m[63:32]);
            en_m[15:0] = 16'hFFFF;
            lines = {32'($urandom), 32'($urandom)};
            @(negedge clk); irq_in = lines;
            settle();
            ref_arb(lines, v, id, pr);
            expect_fwd("R9 random select", v, id, pr);
            rd(12'h184, d); check("R8 level pending view", d, lines[63:32]);
            rd(12'h180, d); check("R2 low inputs ignored", d, {lines[31:16], 16'h0});
        end
        @(negedge clk); irq_in = '0;
        wr(12'h140, 32'hFFFFFFFF); wr(12'h144, 32'hFFFFFFFF);

        // Edge mode on ID 40
        wr(12'h408, 32'h1 << 17);
        wr(12'h228, 32'h00000010); wr(12'h328, 32'h01010101);
        wr(12'h104, 32'h1 << 8);
        @(negedge clk); irq_in[40] = 1'b1;
        @(negedge clk); irq_in[40] = 1'b0;
        settle();
        expect_fwd("R8 edge latched", 1, 40, 8'h10);
        rd(12'h184, d); check("R8 edge pending view", d, 32'h1 << 8);
        do_ack(); settle();
        expect_fwd("R10 acked edge not offered", 0, 0, 0);
        rd(12'h184, d); check("R8 ack clears edge", d, 32'h0);
        do_eoi(40); settle();
        expect_fwd("R8 no re-offer without edge", 0, 0, 0);
        @(negedge clk); irq_in[40] = 1'b1;
        @(negedge clk); irq_in[40] = 1'b0;
        settle();
        expect_fwd("R8 second edge", 1, 40, 8'h10);
        do_ack(); do_eoi(40);
        wr(12'h144, 32'hFFFFFFFF);

        // Level mode with active state on ID 20
        wr(12'h214, 32'h00000020); wr(12'h314, 32'h01010101);
        wr(12'h100, 32'h1 << 20);
        @(negedge clk); irq_in[20] = 1'b1;
        settle();
        expect_fwd("R8 level offered", 1, 20, 8'h20);
        do_ack(); settle();
        expect_fwd("R10 active blocks", 0, 0, 0);
        do_eoi(20); settle();
        expect_fwd("R10 eoi re-offers", 1, 20, 8'h20);
        @(negedge clk); irq_in[20] = 1'b0;
        settle();
        expect_fwd("R8 level drop", 0, 0, 0);
        wr(12'h140, 32'h1 << 20);

        // Tie, priority, target, global enable on IDs 33 and 35
        wr(12'h220, 32'h05000500); wr(12'h320, 32'h01010101);
        wr(12'h104, 32'h0000000A);
        @(negedge clk); irq_in[33] = 1'b1; irq_in[35] = 1'b1;
        settle();
        expect_fwd("R9 tie lowest id", 1, 33, 5);
        wr(12'h220, 32'h03000500); settle();
        expect_fwd("R9 lower value wins", 1, 35, 3);
        wr(12'h320, 32'h02010101); settle();
        expect_fwd("R9 target excludes", 1, 33, 5);
        wr(12'h000, 32'h0); settle();
        expect_fwd("R7 global off", 0, 0, 0);
        wr(12'h000, 32'h1); settle();
        expect_fwd("R7 global on", 1, 33, 5);
        @(negedge clk); irq_in = '0;
        wr(12'h144, 32'hFFFFFFFF);
        settle();

        // Software-generated requests
        wr(12'h008, (32'h02 << 16) | 32'd3); settle();
        rd(12'h180, d); check("R6 other cpu only", d, 32'h0);
        expect_fwd("R6 nothing offered", 0, 0, 0);
        wr(12'h008, (32'h01 << 16) | 32'd5); settle();
        rd(12'h180, d); check("R6 sgi pending", d, 32'h1 << 5);
        expect_fwd("R6 sgi offered", 1, 5, 0);
        @(negedge clk); irq_in[7] = 1'b1; settle();
        rd(12'h180, d); check("R2 input on sgi ignored", d, 32'h1 << 5);
        irq_in[7] = 1'b0;
        do_ack(); settle();
        expect_fwd("R10 sgi acked", 0, 0, 0);
        do_eoi(5); settle();
        expect_fwd("R8 sgi cleared by ack", 0, 0, 0);

        done = 1;
        report();
    end
endmodule